// File: doc/BRIEF.md
# Distributed Self-Routing FIFO Cell Chain

This block is a time-slotted first-come first-served queue. It is built from a row of identical one-packet storage cells and has no central pointer or controller. Each clock cycle is one slot. New packets and read requests enter at the bottom (root) cell. Every cell decides how to route packets using only four signals:

- a packet is present on the link from below;
- a packet is present on the link from above;
- its own slot is occupied;
- a read request has arrived.

Packets travelling upward and read requests both ripple through the chain within the same slot. A packet travelling downward spends one slot in flight on the link between two cells. The root cell's downward link is the egress port.

Each packet carries a 7-bit tag and a hop counter. Every routing decision that touches the packet adds one to the counter. This counter makes the internal path of a packet visible at egress, which lets the queue's self-management be checked from the ports.

Top module: `cell_chain_fifo`

## Requirements
- R1: After reset every cell is empty and the egress valid output is low. The queue holds at most N packets, where N is the number of cells.
- R2: A write in a slot with no read request, while fewer than N packets are queued, is accepted. The occupancy rises by exactly one.
- R3: Packets leave the egress port in the order in which they were written.
- R4: A read request in a slot where the queue is non-empty makes the oldest queued packet appear on egress one clock later.
- R5: A read request on an empty queue with no write produces no egress and changes nothing. Egress is never valid unless a read request was present one clock earlier.
- R6: A write and a read in the same slot on an empty queue send the new packet to egress one clock later, with a hop count of 1.
- R7: A write into a full queue without a read discards only that newest packet. The N older packets stay queued in order, and the discarded packet has passed N cells.
- R8: A write and a read in the same slot on a full queue lose nothing. The occupancy stays N.
- R9: No cell ever holds a stored packet while a packet arrives on its link from above.
- R10: The egress hop count equals the occupancy at the write slot, plus the number of slots between the write and the read that releases the packet, plus one. The count is one lower for a packet written into a full queue together with a read. The count wraps modulo 2^HOP_W.
- R11: A slot with neither a write nor a read leaves the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wrValid | input | 1 | A new packet is offered this slot |
| wrTag | input | TAG_W (7) | Tag of the offered packet |
| rdReq | input | 1 | Read request for this slot |
| egrValid | output | 1 | A packet leaves the queue |
| egrTag | output | TAG_W (7) | Tag of the leaving packet |
| egrHops | output | HOP_W (8) | Routing decisions the leaving packet has passed |

## Verification
The queue is run through several kinds of slot pattern:

- Fill-then-drain sequences show that order is kept (first-in first-out) across the ripple and in-flight paths.
- A write into a full chain separates dropping the newest packet from corrupting the older ones.
- Same-slot read-and-write on an empty, a partly full and a full chain separates the pass-through, hold-in-flight and top-cell paths.
- A mixed random stream of writes and reads, checked against a reference queue that also predicts each hop count, exposes any misrouting. A misrouted packet shows up as a wrong tag or a wrong path length.

// File: rtl/cell_chain_pkg.sv
package cell_chain_pkg;

  // Routing strobes from a cell's control to its datapath.
  // Source: d = from below, u = from above, b = own slot.
  // Destination: b = own slot, u = up link, d = down link.
  typedef struct packed {
    logic d2b;
    logic d2u;
    logic d2d;
    logic u2b;
    logic u2d;
    logic b2b;
    logic b2d;
  } route_t;

endpackage

// File: rtl/cell_route_ctrl.sv
module cell_route_ctrl
  import cell_chain_pkg::*;
#(
  parameter bit IS_TOP = 1'b0
) (
  input  logic   belowV,
  input  logic   aboveV,
  input  logic   bufV,
  input  logic   rdIn,
  output route_t route,
  output logic   rdOut
);

  // Memoryless routing decision for one cell.
  always_comb begin
    route = '0;
    rdOut = 1'b0;
    if (!rdIn) begin
      if (bufV) begin
        route.b2b = 1'b1;
        route.d2u = belowV;
      end else if (aboveV) begin
        route.u2b = 1'b1;
        route.d2u = belowV;
      end else begin
        route.d2b = belowV;
      end
    end else begin
      if (bufV) begin
        route.b2d = 1'b1;
        rdOut     = 1'b1;
        // The top cell frees its slot this slot, so it keeps the newcomer.
        if (IS_TOP) route.d2b = belowV;
        else        route.d2u = belowV;
      end else if (aboveV) begin
        route.u2d = 1'b1;
        rdOut     = 1'b1;
        route.d2u = belowV;
      end else begin
        route.d2d = belowV;
      end
    end
  end

endmodule

// File: rtl/cell_slot_dp.sv
module cell_slot_dp
  import cell_chain_pkg::*;
#(
  parameter int TAG_W = 7,
  parameter int HOP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  route_t           route,
  input  logic             belowV,
  input  logic [TAG_W-1:0] belowTag,
  input  logic [HOP_W-1:0] belowHops,
  input  logic             aboveV,
  input  logic [TAG_W-1:0] aboveTag,
  input  logic [HOP_W-1:0] aboveHops,
  output logic             bufV,
  output logic             upV,
  output logic [TAG_W-1:0] upTag,
  output logic [HOP_W-1:0] upHops,
  output logic             downV,
  output logic [TAG_W-1:0] downTag,
  output logic [HOP_W-1:0] downHops
);

  logic [TAG_W-1:0] bufTag;
  logic [HOP_W-1:0] bufHops;
  logic [HOP_W-1:0] belowNext, aboveNext, bufNext;

  assign belowNext = belowHops + HOP_W'(1);
  assign aboveNext = aboveHops + HOP_W'(1);
  assign bufNext   = bufHops + HOP_W'(1);

  // Upward pass ripples through within the slot.
  assign upV    = belowV & route.d2u;
  assign upTag  = belowTag;
  assign upHops = belowNext;

  always_ff @(posedge clk) begin
    if (rst) begin
      bufV     <= 1'b0;
      bufTag   <= '0;
      bufHops  <= '0;
      downV    <= 1'b0;
      downTag  <= '0;
      downHops <= '0;
    end else begin
      bufV <= route.d2b | route.u2b | route.b2b;
      if (route.d2b) begin
        bufTag  <= belowTag;
        bufHops <= belowNext;
      end else if (route.u2b) begin
        bufTag  <= aboveTag;
        bufHops <= aboveNext;
      end else if (route.b2b) begin
        bufHops <= bufNext;
      end
      downV <= route.d2d | route.u2d | route.b2d;
      if (route.d2d) begin
        downTag  <= belowTag;
        downHops <= belowNext;
      end else if (route.u2d) begin
        downTag  <= aboveTag;
        downHops <= aboveNext;
      end else if (route.b2d) begin
        downTag  <= bufTag;
        downHops <= bufNext;
      end
    end
  end

endmodule

// File: rtl/cell_chain_fifo.sv
module cell_chain_fifo
  import cell_chain_pkg::*;
#(
  parameter int N     = 4,
  parameter int TAG_W = 7,
  parameter int HOP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrValid,
  input  logic [TAG_W-1:0] wrTag,
  input  logic             rdReq,
  output logic             egrValid,
  output logic [TAG_W-1:0] egrTag,
  output logic [HOP_W-1:0] egrHops
);

  localparam int TOP = N - 1;

  logic [N-1:0]     bufOccVec, flightVec, upVec, rdVec;
  logic [TAG_W-1:0] upTagA   [N];
  logic [HOP_W-1:0] upHopsA  [N];
  logic [TAG_W-1:0] dnTagA   [N];
  logic [HOP_W-1:0] dnHopsA  [N];

  // Signals observed by the bound checker.
  logic             dropV;
  logic [TAG_W-1:0] dropTag;
  logic [HOP_W-1:0] dropHops;
  logic             topRdOut;

  for (genvar i = 0; i < N; i++) begin : g_cell
    route_t           route;
    logic             belowV, aboveV, rdIn;
    logic [TAG_W-1:0] belowTag, aboveTag;
    logic [HOP_W-1:0] belowHops, aboveHops;

    if (i == 0) begin : g_root
      assign belowV    = wrValid;
      assign belowTag  = wrTag;
      assign belowHops = '0;
      assign rdIn      = rdReq;
    end else begin : g_inner
      assign belowV    = upVec[i-1];
      assign belowTag  = upTagA[i-1];
      assign belowHops = upHopsA[i-1];
      assign rdIn      = rdVec[i-1];
    end

    if (i == TOP) begin : g_top
      assign aboveV    = 1'b0;
      assign aboveTag  = '0;
      assign aboveHops = '0;
    end else begin : g_below_top
      assign aboveV    = flightVec[i+1];
      assign aboveTag  = dnTagA[i+1];
      assign aboveHops = dnHopsA[i+1];
    end

    cell_route_ctrl #(.IS_TOP(i == TOP)) u_ctrl (
      .belowV (belowV),
      .aboveV (aboveV),
      .bufV   (bufOccVec[i]),
      .rdIn   (rdIn),
      .route  (route),
      .rdOut  (rdVec[i])
    );

    cell_slot_dp #(.TAG_W(TAG_W), .HOP_W(HOP_W)) u_dp (
      .clk       (clk),
      .rst       (rst),
      .route     (route),
      .belowV    (belowV),
      .belowTag  (belowTag),
      .belowHops (belowHops),
      .aboveV    (aboveV),
      .aboveTag  (aboveTag),
      .aboveHops (aboveHops),
      .bufV      (bufOccVec[i]),
      .upV       (upVec[i]),
      .upTag     (upTagA[i]),
      .upHops    (upHopsA[i]),
      .downV     (flightVec[i]),
      .downTag   (dnTagA[i]),
      .downHops  (dnHopsA[i])
    );
  end

  assign dropV    = upVec[TOP];
  assign dropTag  = upTagA[TOP];
  assign dropHops = upHopsA[TOP];
  assign topRdOut = rdVec[TOP];

  assign egrValid = flightVec[0];
  assign egrTag   = dnTagA[0];
  assign egrHops  = dnHopsA[0];

endmodule

// File: rtl/cell_chain_fifo_chk.sv
module cell_chain_fifo_chk #(
  parameter int N     = 4,
  parameter int TAG_W = 7,
  parameter int HOP_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             wrValid,
  input logic [TAG_W-1:0] wrTag,
  input logic             rdReq,
  input logic             egrValid,
  input logic [N-1:0]     bufOccVec,
  input logic [N-1:0]     flightVec,
  input logic             dropV,
  input logic [TAG_W-1:0] dropTag,
  input logic [HOP_W-1:0] dropHops,
  input logic             topRdOut
);

  localparam int CNT_W = $clog2(N + 1) + 1;

  logic [CNT_W-1:0] occ;
  always_comb occ = CNT_W'($countones(bufOccVec)) + CNT_W'($countones(flightVec >> 1));

  AST_NO_STACKED: assert property (@(posedge clk) disable iff (rst)
    (bufOccVec & (flightVec >> 1)) == '0); // R9
  AST_CAPACITY: assert property (@(posedge clk) disable iff (rst)
    occ <= CNT_W'(N)); // R1
  AST_FILL: assert property (@(posedge clk) disable iff (rst)
    wrValid && !rdReq && occ < CNT_W'(N) |=> occ == $past(occ) + CNT_W'(1)); // R2
  AST_READ_SERVED: assert property (@(posedge clk) disable iff (rst)
    rdReq && (occ != '0 || wrValid) |=> egrValid); // R4
  AST_EGRESS_NEEDS_READ: assert property (@(posedge clk) disable iff (rst)
    egrValid |-> $past(rdReq)); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    dropV |-> (occ == CNT_W'(N) && wrValid && !rdReq)); // R7
  AST_DROP_NEWEST: assert property (@(posedge clk) disable iff (rst)
    dropV |-> (dropTag == wrTag && dropHops == HOP_W'(N))); // R7
  AST_FULL_RW: assert property (@(posedge clk) disable iff (rst)
    rdReq && wrValid && occ == CNT_W'(N) |=> occ == CNT_W'(N)); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !rdReq && !wrValid |=> occ == $past(occ)); // R11
  AST_TOP_READ: assert property (@(posedge clk) disable iff (rst)
    topRdOut |=> flightVec[N-1]); // R4

endmodule

bind cell_chain_fifo cell_chain_fifo_chk #(.N(N), .TAG_W(TAG_W), .HOP_W(HOP_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wrValid   (wrValid),
  .wrTag     (wrTag),
  .rdReq     (rdReq),
  .egrValid  (egrValid),
  .bufOccVec (bufOccVec),
  .flightVec (flightVec),
  .dropV     (dropV),
  .dropTag   (dropTag),
  .dropHops  (dropHops),
  .topRdOut  (topRdOut)
);

// File: tb/cell_chain_fifo_bench.sv
module cell_chain_fifo_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N     = 4;
  localparam int TAG_W = 7;
  localparam int HOP_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wrValid = 1'b0;
  logic [TAG_W-1:0] wrTag = '0;
  logic             rdReq = 1'b0;
  logic             egrValid;
  logic [TAG_W-1:0] egrTag;
  logic [HOP_W-1:0] egrHops;

  cell_chain_fifo #(.N(N), .TAG_W(TAG_W), .HOP_W(HOP_W)) u_cell_chain_fifo (
    .clk(clk), .rst(rst), .wrValid(wrValid), .wrTag(wrTag), .rdReq(rdReq),
    .egrValid(egrValid), .egrTag(egrTag), .egrHops(egrHops)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // Reference queue: tag, occupancy at entry, entry slot, hop adjustment.
  int qTag [N];
  int qOcc [N];
  int qCyc [N];
  int qAdj [N];
  int qCnt = 0;
  int slotNo = 0;
  int nextTag = 1;

  task automatic checkEq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int expHops(int occAt, int cycAt, int adj, int now);
    return (occAt + (now - cycAt) + 1 - adj) % (1 << HOP_W);
  endfunction

  task automatic push(int tg, int occAt, int adj);
    qTag[qCnt] = tg;
    qOcc[qCnt] = occAt;
    qCyc[qCnt] = slotNo;
    qAdj[qCnt] = adj;
    qCnt++;
  endtask

  task automatic slot(bit w, bit r, string req);
    int eV = 0;
    int eTag = 0;
    int eHops = 0;
    int prev = qCnt;
    int tg = nextTag;
    if (w) nextTag = (nextTag + 1) % 128;
    wrValid = w;
    wrTag   = TAG_W'(tg);
    rdReq   = r;
    if (r && qCnt > 0) begin
      eV = 1;
      eTag = qTag[0];
      eHops = expHops(qOcc[0], qCyc[0], qAdj[0], slotNo);
      for (int k = 0; k < N - 1; k++) begin
        qTag[k] = qTag[k+1]; qOcc[k] = qOcc[k+1];
        qCyc[k] = qCyc[k+1]; qAdj[k] = qAdj[k+1];
      end
      qCnt--;
      if (w) push(tg, prev, (prev == N) ? 1 : 0);
    end else if (r && w) begin
      eV = 1; eTag = tg; eHops = 1;
    end else if (w && qCnt < N) begin
      push(tg, prev, 0);
    end
    @(posedge clk);
    @(negedge clk);
    wrValid = 1'b0;
    rdReq   = 1'b0;
    checkEq(req, "egress valid", int'(egrValid), eV);
    if (eV != 0 && egrValid) begin
      checkEq(req, "egress tag", int'(egrTag), eTag);
      checkEq("R10", "egress hops", int'(egrHops), eHops);
    end
    slotNo++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R1 watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    checkEq("R1", "egress valid after reset", int'(egrValid), 0);

    slot(0, 1, "R5");                         // read on empty
    slot(0, 0, "R11");
    for (int k = 0; k < N; k++) slot(1, 0, "R2");
    slot(1, 0, "R7");                         // overflow drops newest
    slot(0, 0, "R11");
    for (int k = 0; k < N; k++) slot(0, 1, "R3");
    slot(0, 1, "R5");
    slot(1, 1, "R6");                         // pass-through on empty
    for (int k = 0; k < N; k++) slot(1, 0, "R2");
    for (int k = 0; k < 3; k++) slot(1, 1, "R8");  // full, read and write
    for (int k = 0; k < N; k++) slot(0, 1, "R4");
    // Short mixed pattern: write, write, read, idle, both, read, both, idle.
    slot(1, 0, "R2"); slot(1, 0, "R2"); slot(0, 1, "R4"); slot(0, 0, "R11");
    slot(1, 1, "R4"); slot(0, 1, "R4"); slot(1, 1, "R6"); slot(0, 0, "R11");
    slot(1, 0, "R2"); slot(1, 1, "R4"); slot(0, 0, "R11"); slot(0, 1, "R4");

    for (int k = 0; k < 4000; k++) begin
      bit w = ($urandom % 100) < 45;
      bit r = ($urandom % 100) < 42;
      slot(w, r, "R3");
    end
    for (int k = 0; k < N + 1; k++) slot(0, 1, "R3");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule